// File: doc/BRIEF.md
# Long Multiply-Accumulate Unit

This unit forms the full 64-bit product of two 32-bit operands. It can also add that product to a 64-bit running value that arrives as a high word and a low word. A 2-bit operation code picks one of four modes: unsigned or two's-complement operands, each with or without accumulation. The result leaves as a high word and a low word. When the caller asks for a flag update, the unit also returns a negative flag and a zero flag, together with a strobe that writes only those two flags.

The datapath is iterative. It consumes the multiplier one digit per clock. A signed multiplier is handled by a correction subtracted into the starting sum, so the signed and unsigned modes share one add chain. A caller raises `start` for one cycle while `busy` is low. After a fixed number of cycles the unit raises `done` for one cycle, and the result words stay stable until the next completion. A `start` that arrives while the unit is busy is dropped.

Top module: `lmac_unit`

## Requirements
- R1: With `op` = 2'b00, the result equals `src_a` × `src_b` taken as unsigned integers. Bits 31:0 of the 64-bit result appear on `res_lo` and bits 63:32 on `res_hi`.
- R2: With `op` = 2'b10, the result equals `src_a` × `src_b` taken as two's-complement integers. For example, 0x80000000 × 0x80000000 gives 0x4000000000000000.
- R3: With `op` = 2'b01, the result equals the unsigned product plus {`acc_hi`,`acc_lo`}, wrapped modulo 2^64, with no overflow indication.
- R4: With `op` = 2'b11, the result equals the signed product plus {`acc_hi`,`acc_lo`}, wrapped modulo 2^64.
- R5: In the two non-accumulating modes (`op[0]` = 0), the values on `acc_hi` and `acc_lo` have no effect on the result.
- R6: `done` is high for exactly one cycle, 4 clock edges after the edge that accepts `start`. `busy` is high from the accepting edge until `done` rises, and the result outputs hold their value between completions.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The operation already running completes with its own operands and its own latency, and no extra `done` follows.
- R8: When `set_flags` was high at the accepting edge, `flag_nz_we` is high together with `done`. In that cycle `flag_n` equals result bit 63 and `flag_z` is high only when all 64 result bits are zero. When `set_flags` was low, `flag_nz_we` stays low. The unit drives no carry or overflow write.
- R9: After reset, `busy`, `done` and `flag_nz_we` are low and both result words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches an operation when `busy` is low |
| op | input | 2 | Mode: 00 unsigned mul, 01 unsigned mul-acc, 10 signed mul, 11 signed mul-acc |
| set_flags | input | 1 | Requests an N/Z flag update for this operation |
| src_a | input | 32 | Multiplicand |
| src_b | input | 32 | Multiplier |
| acc_hi | input | 32 | Upper word of the addend |
| acc_lo | input | 32 | Lower word of the addend |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 32 | Result bits 63:32 |
| res_lo | output | 32 | Result bits 31:0 |
| flag_n | output | 1 | Negative flag (result bit 63) |
| flag_z | output | 1 | Zero flag (all 64 result bits zero) |
| flag_nz_we | output | 1 | Write strobe for the N and Z flags only |

## Verification
Every result, both flags and the flag strobe become due on the fourth rising edge after the edge that accepts `start`, all in the same cycle as `done`. `busy` rises on the accepting edge itself. The bench drives inputs on falling edges and then counts falling edges until `done` appears. It requires that count to be exactly four and compares the result words and flags in that same half-cycle. To check that a start arriving mid-operation is dropped, the bench watches for the original result at the original latency and then waits several more cycles to confirm that no second `done` follows.

// File: rtl/lmac_pkg.sv
package lmac_pkg;

  typedef enum logic [1:0] {
    OP_UMUL = 2'b00,
    OP_UMAC = 2'b01,
    OP_SMUL = 2'b10,
    OP_SMAC = 2'b11
  } lmac_op_e;

  // operands treated as two's complement
  function automatic logic op_is_signed(input logic [1:0] op);
    return op[1];
  endfunction

  // product is added to the incoming 64-bit value
  function automatic logic op_accumulates(input logic [1:0] op);
    return op[0];
  endfunction

endpackage

// File: rtl/lmac_seed.sv
// Forms the widened multiplicand and the starting partial sum.
// A signed multiplier B equals unsigned(B) - b_msb * 2^OPW, so the
// correction term is folded into the seed and the iteration stays unsigned.
module lmac_seed #(
  parameter int OPW = 32,
  localparam int RW = 2 * OPW
) (
  input  logic [1:0]     op,
  input  logic [OPW-1:0] src_a,
  input  logic           b_msb,
  input  logic [RW-1:0]  addend,
  output logic [RW-1:0]  mcand_ext,
  output logic [RW-1:0]  seed
);
  import lmac_pkg::*;

  function automatic logic [RW-1:0] widen(input logic [OPW-1:0] v, input logic sgn);
    return sgn ? {{OPW{v[OPW-1]}}, v} : {{OPW{1'b0}}, v};
  endfunction

  function automatic logic [RW-1:0] msb_fix(input logic [RW-1:0] m, input logic apply);
    return apply ? (m << OPW) : '0;
  endfunction

  logic sgn;
  logic [RW-1:0] base;

  always_comb begin
    sgn       = op_is_signed(op);
    mcand_ext = widen(src_a, sgn);
    base      = op_accumulates(op) ? addend : '0;
    seed      = base - msb_fix(mcand_ext, sgn & b_msb);
  end

endmodule

// File: rtl/lmac_digit_step.sv
// Adds one multiplier digit's worth of partial products to the running sum.
module lmac_digit_step #(
  parameter int W  = 64,
  parameter int DB = 8
) (
  input  logic [W-1:0]  sum_in,
  input  logic [W-1:0]  mcand,
  input  logic [DB-1:0] digit,
  output logic [W-1:0]  sum_out
);
  logic [W-1:0] pp [DB];

  for (genvar g = 0; g < DB; g++) begin : g_pp
    assign pp[g] = digit[g] ? (mcand << g) : '0;
  end

  always_comb begin
    sum_out = sum_in;
    for (int i = 0; i < DB; i++) sum_out = sum_out + pp[i];
  end

endmodule

// File: rtl/lmac_flags.sv
// Negative / zero condition of a full-width result.
module lmac_flags #(
  parameter int W = 64
) (
  input  logic [W-1:0] value,
  output logic         neg,
  output logic         zero
);
  function automatic logic is_zero(input logic [W-1:0] v);
    return ~|v;
  endfunction

  assign neg  = value[W-1];
  assign zero = is_zero(value);

endmodule

// File: rtl/lmac_unit.sv
module lmac_unit #(
  parameter int OPW        = 32,
  parameter int DIGIT_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic             set_flags,
  input  logic [OPW-1:0]   src_a,
  input  logic [OPW-1:0]   src_b,
  input  logic [OPW-1:0]   acc_hi,
  input  logic [OPW-1:0]   acc_lo,
  output logic             busy,
  output logic             done,
  output logic [OPW-1:0]   res_hi,
  output logic [OPW-1:0]   res_lo,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_nz_we
);
  localparam int RW    = 2 * OPW;
  localparam int ITERS = OPW / DIGIT_BITS;
  localparam int CNTW  = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CNTW-1:0] LAST_CNT = CNTW'(ITERS - 1);

  // state
  logic            busy_q, done_q, we_q, freq_q, n_q, z_q;
  logic [CNTW-1:0] cnt_q;
  logic [RW-1:0]   sum_q, mcand_q, res_q;
  logic [OPW-1:0]  mlier_q;

  // named internal events
  logic            accept, last_step;
  logic [RW-1:0]   seed, mcand_ext, step_sum;
  logic            step_neg, step_zero;

  assign accept    = start & ~busy_q;
  assign last_step = busy_q & (cnt_q == LAST_CNT);

  lmac_seed #(.OPW(OPW)) u_seed (
    .op        (op),
    .src_a     (src_a),
    .b_msb     (src_b[OPW-1]),
    .addend    ({acc_hi, acc_lo}),
    .mcand_ext (mcand_ext),
    .seed      (seed)
  );

  lmac_digit_step #(.W(RW), .DB(DIGIT_BITS)) u_step (
    .sum_in  (sum_q),
    .mcand   (mcand_q),
    .digit   (mlier_q[DIGIT_BITS-1:0]),
    .sum_out (step_sum)
  );

  lmac_flags #(.W(RW)) u_flags (
    .value (step_sum),
    .neg   (step_neg),
    .zero  (step_zero)
  );

  // iteration sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      sum_q   <= '0;
      mcand_q <= '0;
      mlier_q <= '0;
      freq_q  <= 1'b0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      sum_q   <= seed;
      mcand_q <= mcand_ext;
      mlier_q <= src_b;
      freq_q  <= set_flags;
    end else if (busy_q) begin
      sum_q   <= step_sum;
      mcand_q <= mcand_q << DIGIT_BITS;
      mlier_q <= mlier_q >> DIGIT_BITS;
      cnt_q   <= cnt_q + 1'b1;
      if (last_step) busy_q <= 1'b0;
    end
  end

  // result and flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      we_q   <= 1'b0;
      res_q  <= '0;
      n_q    <= 1'b0;
      z_q    <= 1'b0;
    end else begin
      done_q <= last_step;
      we_q   <= last_step & freq_q;
      if (last_step) begin
        res_q <= step_sum;
        n_q   <= step_neg;
        z_q   <= step_zero;
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign res_hi     = res_q[RW-1:OPW];
  assign res_lo     = res_q[OPW-1:0];
  assign flag_n     = n_q;
  assign flag_z     = z_q;
  assign flag_nz_we = we_q;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && cnt_q == '0));
  // R7
  busy_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
  // R8
  strobe_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_nz_we |-> done);
  // R8
  flag_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_n == res_hi[OPW-1] && flag_z == ({res_hi, res_lo} == '0)));
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_hi) && $stable(res_lo)));

endmodule

// File: tb/lmac_unit_tb.sv
module lmac_unit_tb_top;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        set_flags = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, acc_hi = '0, acc_lo = '0;
  logic        busy, done, flag_n, flag_z, flag_nz_we;
  logic [31:0] res_hi, res_lo;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  lmac_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .set_flags(set_flags),
    .src_a(src_a), .src_b(src_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
    .flag_n(flag_n), .flag_z(flag_z), .flag_nz_we(flag_nz_we)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, cycles %0d expected below 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [63:0] acc);
    logic signed [63:0] sa, sb;
    logic [63:0] p;
    sa = $signed(a);
    sb = $signed(b);
    if (o[1]) p = sa * sb;
    else      p = {32'h0, a} * {32'h0, b};
    if (o[0]) p = p + acc;
    return p;
  endfunction

  function automatic string tag_of(input logic [1:0] o);
    case (o)
      2'b00:   return "R1";
      2'b01:   return "R3";
      2'b10:   return "R2";
      default: return "R4";
    endcase
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Runs one operation and checks latency, result, flags and strobe.
  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] acc, input logic sf, input logic [63:0] exp,
                        input string tag, input bit poke_busy);
    int lat;
    @(negedge clk);
    op = o; src_a = a; src_b = b; {acc_hi, acc_lo} = acc; set_flags = sf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      if (poke_busy && lat == 1) begin
        // R7: a second start while busy, different operands and mode
        op = ~o; src_a = ~a; src_b = b ^ 32'h5A5A_A5A5; set_flags = ~sf; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check64({tag, " latency (R6)"}, 64'(lat), 64'(LAT));
    check64(tag, {res_hi, res_lo}, exp);
    check64("R8 strobe", 64'(flag_nz_we), 64'(sf));
    if (sf) begin
      check64("R8 flag_n", 64'(flag_n), 64'(exp[63]));
      check64("R8 flag_z", 64'(flag_z), 64'(exp == 64'h0));
    end
  endtask

  logic [31:0] vals [8];

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h0000_0002;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'hFFFF_FFFF;
    vals[6] = 32'h1234_5678; vals[7] = 32'hDEAD_BEEF;

    repeat (3) @(negedge clk);
    // R9: reset state
    check64("R9 busy", 64'(busy), 64'h0);
    check64("R9 done", 64'(done), 64'h0);
    check64("R9 strobe", 64'(flag_nz_we), 64'h0);
    check64("R9 result", {res_hi, res_lo}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // named corner cases
    run_op(2'b10, 32'h8000_0000, 32'h8000_0000, 64'h0, 1'b1, 64'h4000_0000_0000_0000, "R2 corner", 1'b0);
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0, 1'b1, 64'hFFFF_FFFE_0000_0001, "R1 corner", 1'b0);
    run_op(2'b10, 32'hFFFF_FFFF, 32'h0000_0003, 64'h0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFD, "R2 neg", 1'b0);
    run_op(2'b01, 32'h1, 32'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0, "R3 wrap", 1'b0);
    run_op(2'b11, 32'hFFFF_FFFF, 32'h1, 64'h1, 1'b1, 64'h0, "R4 zero", 1'b0);
    run_op(2'b00, 32'h0, 32'hDEAD_BEEF, 64'hFFFF_0000_1234_5678, 1'b1, 64'h0, "R5 ignore acc", 1'b0);
    run_op(2'b10, 32'h3, 32'h5, 64'hAAAA_5555_AAAA_5555, 1'b0, 64'd15, "R5 ignore acc", 1'b0);

    // R7: start during busy is dropped
    run_op(2'b00, 32'h0001_0000, 32'h0001_0000, 64'h0, 1'b0, 64'h1_0000_0000, "R7 busy start", 1'b1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check64("R7 no extra done", 64'(done), 64'h0);
    end

    // sweep over modes, operand pairs and addends
    for (int o = 0; o < 4; o++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [63:0] acc;
          acc = {vals[(i + j) % 8], vals[(i * 5 + j + o) % 8]};
          run_op(2'(o), vals[i], vals[j], acc, 1'((i + j + o) & 1),
                 model(2'(o), vals[i], vals[j], acc), tag_of(2'(o)), 1'b0);
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule